// File: doc/BRIEF.md
# TDM Frame Multiplexer and Deframer

This block builds a fixed time-division frame out of two 8-bit audio sample channels and a stream of video bytes, then shifts the frame out one bit at a time. A frame is eight 8-bit slots. A 16-bit sync word fills the first two slots, each audio channel takes one slot, and four slots carry video. A frame strobe starts each frame. The serial output has a one-clock bit-enable and a marker on the first bit of every frame. Video bytes arrive over a valid/ready handshake into a four-entry holding buffer, which is emptied into each frame as it starts.

The receive half takes a serial bit stream with its own bit-enable. It hunts bit by bit for the sync word. It declares lock once the word has recurred at a fixed 64-bit spacing in three frames in a row. It drops lock after two sync words in a row are missing. While locked it hands back each payload slot with a strobe and a slot number. The two halves share only the clock and reset, so a bench or a neighbouring block can loop the serial line back or put a channel in between.

Top module: `tdm_frame_link`

## Requirements
- R1: Each frame is exactly 64 bits, sent MSB first. The slot order is 0xAA then 0x55, then `sine_a`, then `sine_b`, then video bytes 0 to 3 in arrival order.
- R2: While a frame is in progress, `ser_en` is high for exactly one clock in every 8 clocks (BIT_DIV = 8). The first bit is valid in the clock after the start strobe is taken.
- R3: `ser_sof` is high together with `ser_en` on bit 0 of a frame and on no other bit.
- R4: `frame_go` is taken only when the transmitter is idle or in the final clock of a frame. A strobe at any other time has no effect on the frame being sent.
- R5: The video buffer accepts up to 4 bytes and keeps their arrival order. `vid_ready` is low while 4 bytes are held and in the clock in which a frame start is taken.
- R6: At frame start the sine inputs and the buffered video bytes are captured. Video slots with no buffered byte carry 0x00. When fewer than 4 bytes were held, `tx_underflow` goes high for that frame and stays until the next frame start.
- R7: The receiver asserts `rx_locked` at the end of the third sync word seen at a constant 64-bit spacing. It is not asserted after only one or two.
- R8: Once locked, a single missing sync word keeps the lock. Two consecutive missing sync words clear `rx_locked` at the end of the second.
- R9: After losing lock, the receiver searches bit by bit again and needs three sync words in a row before it locks again.
- R10: While locked, every frame gives six one-clock `rx_strobe` pulses, with `rx_slot` = 2 for sine_a, 3 for sine_b and 4 to 7 for video bytes 0 to 3, and `rx_byte` equal to that slot's value. No strobe occurs while unlocked.
- R11: After reset `ser_en`, `ser_sof`, `tx_underflow`, `rx_locked` and `rx_strobe` are low and `vid_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Start strobe for one frame |
| sine_a | input | 8 | First audio sample, captured at frame start |
| sine_b | input | 8 | Second audio sample, captured at frame start |
| vid_valid | input | 1 | Video byte offered |
| vid_data | input | 8 | Video byte |
| vid_ready | output | 1 | Video byte can be taken this clock |
| ser_bit | output | 1 | Serial frame data, MSB first |
| ser_en | output | 1 | Serial bit valid strobe |
| ser_sof | output | 1 | Marks bit 0 of a frame |
| tx_underflow | output | 1 | Current frame had fewer than 4 video bytes |
| rx_bit | input | 1 | Received serial data |
| rx_en | input | 1 | Received bit valid strobe |
| rx_locked | output | 1 | Receiver is aligned to the frame |
| rx_strobe | output | 1 | Recovered payload byte valid |
| rx_slot | output | 3 | Slot number of the recovered byte (2 to 7) |
| rx_byte | output | 8 | Recovered payload byte |

## Verification
The transmit side is swept across every video fill level from empty to full, with different sine values each time. Every 64-bit frame is compared whole, which separates zero fill and underflow handling from ordering mistakes in the slots. One frame gets a second start strobe halfway through, which shows whether a busy transmitter ever restarts. The receive side is fed its own transmit output, and single bits of chosen sync words are flipped. This separates the lock threshold, the single-miss tolerance, the two-miss drop and the relock count. The slot strobes are checked against the sent bytes in every frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Receiver alignment states
    typedef enum logic [1:0] {
        DF_SEARCH = 2'd0,
        DF_VERIFY = 2'd1,
        DF_LOCKED = 2'd2
    } df_state_e;

    // Slots ahead of the video payload: two sync slots and two sine slots
    localparam int SYNC_SLOTS = 2;
    localparam int SINE_SLOTS = 2;

endpackage

// File: rtl/tdm_vid_buf.sv
module tdm_vid_buf #(
    parameter int SLOT_W = 8,
    parameter int DEPTH  = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SLOT_W-1:0]         in_data,
    output logic                      in_ready,
    input  logic                      take,
    output logic [DEPTH*SLOT_W-1:0]   bytes,
    output logic [CW-1:0]             count
);

    typedef struct packed {
        logic [DEPTH-1:0][SLOT_W-1:0] mem;
        logic [CW-1:0]                cnt;
    } vb_t;

    vb_t vb_d, vb_q;

    assign in_ready = (vb_q.cnt != CW'(DEPTH)) && !take;
    assign count    = vb_q.cnt;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign bytes[g*SLOT_W +: SLOT_W] = vb_q.mem[g];
        end
    endgenerate

    always_comb begin
        vb_d = vb_q;
        if (take) begin
            vb_d.cnt = '0;
        end else if (in_valid && in_ready) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (vb_q.cnt == CW'(k)) vb_d.mem[k] = in_data;
            end
            vb_d.cnt = vb_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vb_q <= '0;
        else        vb_q <= vb_d;
    end

    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vb_q.cnt <= CW'(DEPTH));

    // R5
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (vb_q.cnt == $past(vb_q.cnt) + CW'(1)));

    // R6
    take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (vb_q.cnt == '0));

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer #(
    parameter int SLOT_W                  = 8,
    parameter int VID_SLOTS               = 4,
    parameter int BIT_DIV                 = 8,
    parameter logic [2*SLOT_W-1:0] SYNC_WORD = 16'hAA55,
    localparam int VCW                    = $clog2(VID_SLOTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_go,
    input  logic [SLOT_W-1:0]            sine_a,
    input  logic [SLOT_W-1:0]            sine_b,
    input  logic [VID_SLOTS*SLOT_W-1:0]  vid_bytes,
    input  logic [VCW-1:0]               vid_count,
    output logic                         start,
    output logic                         ser_bit,
    output logic                         ser_en,
    output logic                         ser_sof,
    output logic                         underflow
);
    import tdm_pkg::*;

    localparam int N_SLOTS    = SYNC_SLOTS + SINE_SLOTS + VID_SLOTS;
    localparam int FRAME_BITS = N_SLOTS * SLOT_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DIV_W      = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;

    typedef struct packed {
        logic                  busy;
        logic [DIV_W-1:0]      div;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  uflow;
    } fr_t;

    fr_t fr_d, fr_q;
    logic                          last;
    logic [VID_SLOTS*SLOT_W-1:0]   vid_field;
    logic [FRAME_BITS-1:0]         frame_word;

    assign last  = fr_q.busy && (fr_q.div == DIV_W'(BIT_DIV - 1))
                   && (fr_q.idx == IDX_W'(FRAME_BITS - 1));
    assign start = frame_go && (!fr_q.busy || last);

    always_comb begin
        vid_field = '0;
        for (int k = 0; k < VID_SLOTS; k++) begin
            if (VCW'(k) < vid_count)
                vid_field[(VID_SLOTS-1-k)*SLOT_W +: SLOT_W] = vid_bytes[k*SLOT_W +: SLOT_W];
        end
        frame_word = {SYNC_WORD, sine_a, sine_b, vid_field};

        fr_d = fr_q;
        if (fr_q.busy) begin
            if (fr_q.div == DIV_W'(BIT_DIV - 1)) begin
                fr_d.div = '0;
                fr_d.idx = fr_q.idx + IDX_W'(1);
                fr_d.sh  = {fr_q.sh[FRAME_BITS-2:0], 1'b0};
                if (fr_q.idx == IDX_W'(FRAME_BITS - 1)) fr_d.busy = 1'b0;
            end else begin
                fr_d.div = fr_q.div + DIV_W'(1);
            end
        end
        if (start) begin
            fr_d.busy  = 1'b1;
            fr_d.div   = '0;
            fr_d.idx   = '0;
            fr_d.sh    = frame_word;
            fr_d.uflow = (vid_count < VCW'(VID_SLOTS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign ser_bit   = fr_q.sh[FRAME_BITS-1];
    assign ser_en    = fr_q.busy && (fr_q.div == '0);
    assign ser_sof   = ser_en && (fr_q.idx == '0);
    assign underflow = fr_q.uflow;

    // R3
    sof_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ser_sof);

    // R4
    busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.busy && !last && frame_go) |=> !ser_sof);

    // R6
    short_fill_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (vid_count < VCW'(VID_SLOTS))) |=> underflow);

    generate
        if (BIT_DIV > 1) begin : g_pulse
            // R2
            bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ser_en |=> !ser_en);
        end
    endgenerate

endmodule

// File: rtl/tdm_deframer.sv
module tdm_deframer #(
    parameter int SLOT_W                  = 8,
    parameter int VID_SLOTS               = 4,
    parameter int LOCK_HITS               = 3,
    parameter int LOSS_MISSES             = 2,
    parameter logic [2*SLOT_W-1:0] SYNC_WORD = 16'hAA55,
    localparam int SIW = $clog2(tdm_pkg::SYNC_SLOTS + tdm_pkg::SINE_SLOTS + VID_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_en,
    output logic              locked,
    output logic              strobe,
    output logic [SIW-1:0]    slot,
    output logic [SLOT_W-1:0] data
);
    import tdm_pkg::*;

    localparam int N_SLOTS    = SYNC_SLOTS + SINE_SLOTS + VID_SLOTS;
    localparam int FRAME_BITS = N_SLOTS * SLOT_W;
    localparam int SYNC_W     = SYNC_SLOTS * SLOT_W;
    localparam int DATA_BITS  = FRAME_BITS - SYNC_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int HW         = $clog2(LOCK_HITS + 1);
    localparam int MW         = $clog2(LOSS_MISSES + 1);

    typedef struct packed {
        df_state_e          st;
        logic [SYNC_W-1:0]  hist;
        logic [IDX_W-1:0]   pos;
        logic [HW-1:0]      hits;
        logic [MW-1:0]      miss;
        logic               strobe;
        logic [SIW-1:0]     slot;
        logic [SLOT_W-1:0]  data;
    } df_t;

    df_t df_d, df_q;
    logic [SYNC_W-1:0] hist_nx;
    logic              hit;

    assign hist_nx = {df_q.hist[SYNC_W-2:0], rx_bit};
    assign hit     = (hist_nx == SYNC_WORD);

    always_comb begin
        df_d        = df_q;
        df_d.strobe = 1'b0;
        if (rx_en) begin
            df_d.hist = hist_nx;
            if (df_q.st == DF_SEARCH) begin
                if (hit) begin
                    df_d.pos  = '0;
                    df_d.hits = HW'(1);
                    df_d.miss = '0;
                    df_d.st   = (LOCK_HITS <= 1) ? DF_LOCKED : DF_VERIFY;
                end
            end else begin
                df_d.pos = df_q.pos + IDX_W'(1);
                if (df_q.st == DF_LOCKED && int'(df_q.pos) < DATA_BITS
                    && (int'(df_q.pos) % SLOT_W) == SLOT_W - 1) begin
                    df_d.strobe = 1'b1;
                    df_d.slot   = SIW'(SYNC_SLOTS + int'(df_q.pos) / SLOT_W);
                    df_d.data   = hist_nx[SLOT_W-1:0];
                end
                if (df_q.pos == IDX_W'(FRAME_BITS - 1)) begin
                    df_d.pos = '0;
                    if (df_q.st == DF_VERIFY) begin
                        if (hit) begin
                            df_d.hits = df_q.hits + HW'(1);
                            if (int'(df_q.hits) + 1 >= LOCK_HITS) df_d.st = DF_LOCKED;
                        end else begin
                            df_d.st = DF_SEARCH;
                        end
                    end else begin
                        if (hit) begin
                            df_d.miss = '0;
                        end else if (int'(df_q.miss) + 1 >= LOSS_MISSES) begin
                            df_d.st   = DF_SEARCH;
                            df_d.miss = '0;
                        end else begin
                            df_d.miss = df_q.miss + MW'(1);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            df_q      <= '0;
            df_q.st   <= DF_SEARCH;
        end else begin
            df_q      <= df_d;
        end
    end

    assign locked = (df_q.st == DF_LOCKED);
    assign strobe = df_q.strobe;
    assign slot   = df_q.slot;
    assign data   = df_q.data;

    // R10
    strobe_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($past(df_q.st == DF_LOCKED) && $past(rx_en)));

    // R7
    lock_via_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(df_q.st == DF_VERIFY || LOCK_HITS <= 1));

    // R8
    unlock_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(rx_en && df_q.pos == IDX_W'(FRAME_BITS - 1)));

    // R9
    search_idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (df_q.st == DF_SEARCH && !rx_en) |=> $stable(df_q.st));

endmodule

// File: rtl/tdm_frame_link.sv
module tdm_frame_link #(
    parameter int SLOT_W      = 8,
    parameter int VID_SLOTS   = 4,
    parameter int BIT_DIV     = 8,
    parameter int LOCK_HITS   = 3,
    parameter int LOSS_MISSES = 2,
    parameter logic [2*SLOT_W-1:0] SYNC_WORD = 16'hAA55,
    localparam int SIW = $clog2(tdm_pkg::SYNC_SLOTS + tdm_pkg::SINE_SLOTS + VID_SLOTS),
    localparam int VCW = $clog2(VID_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic [SLOT_W-1:0] sine_a,
    input  logic [SLOT_W-1:0] sine_b,
    input  logic              vid_valid,
    input  logic [SLOT_W-1:0] vid_data,
    output logic              vid_ready,
    output logic              ser_bit,
    output logic              ser_en,
    output logic              ser_sof,
    output logic              tx_underflow,
    input  logic              rx_bit,
    input  logic              rx_en,
    output logic              rx_locked,
    output logic              rx_strobe,
    output logic [SIW-1:0]    rx_slot,
    output logic [SLOT_W-1:0] rx_byte
);

    logic                        start;
    logic [VID_SLOTS*SLOT_W-1:0] vid_bytes;
    logic [VCW-1:0]              vid_count;

    tdm_vid_buf #(
        .SLOT_W (SLOT_W),
        .DEPTH  (VID_SLOTS)
    ) u_vid_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (vid_valid),
        .in_data  (vid_data),
        .in_ready (vid_ready),
        .take     (start),
        .bytes    (vid_bytes),
        .count    (vid_count)
    );

    tdm_framer #(
        .SLOT_W    (SLOT_W),
        .VID_SLOTS (VID_SLOTS),
        .BIT_DIV   (BIT_DIV),
        .SYNC_WORD (SYNC_WORD)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_go  (frame_go),
        .sine_a    (sine_a),
        .sine_b    (sine_b),
        .vid_bytes (vid_bytes),
        .vid_count (vid_count),
        .start     (start),
        .ser_bit   (ser_bit),
        .ser_en    (ser_en),
        .ser_sof   (ser_sof),
        .underflow (tx_underflow)
    );

    tdm_deframer #(
        .SLOT_W      (SLOT_W),
        .VID_SLOTS   (VID_SLOTS),
        .LOCK_HITS   (LOCK_HITS),
        .LOSS_MISSES (LOSS_MISSES),
        .SYNC_WORD   (SYNC_WORD)
    ) u_deframer (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_bit (rx_bit),
        .rx_en  (rx_en),
        .locked (rx_locked),
        .strobe (rx_strobe),
        .slot   (rx_slot),
        .data   (rx_byte)
    );

endmodule

// File: tb/tdm_frame_link_tb.sv
module tdm_frame_link_tb;

    localparam int BD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_go = 1'b0;
    logic       vid_valid = 1'b0;
    logic       flip = 1'b0;
    logic [7:0] sine_a = '0;
    logic [7:0] sine_b = '0;
    logic [7:0] vid_data = '0;
    logic       vid_ready, ser_bit, ser_en, ser_sof, tx_underflow;
    logic       rx_bit, rx_locked, rx_strobe;
    logic [2:0] rx_slot;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int frame_no = 0;
    logic [7:0] vb [4];

    assign rx_bit = ser_bit ^ flip;

    always #2 clk = ~clk;

    tdm_frame_link u_dut (
        .clk (clk), .rst_n (rst_n), .frame_go (frame_go),
        .sine_a (sine_a), .sine_b (sine_b),
        .vid_valid (vid_valid), .vid_data (vid_data), .vid_ready (vid_ready),
        .ser_bit (ser_bit), .ser_en (ser_en), .ser_sof (ser_sof),
        .tx_underflow (tx_underflow),
        .rx_bit (rx_bit), .rx_en (ser_en), .rx_locked (rx_locked),
        .rx_strobe (rx_strobe), .rx_slot (rx_slot), .rx_byte (rx_byte)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        vid_valid = 1'b1;
        vid_data  = d;
        while (!vid_ready) @(negedge clk);
        @(negedge clk);
        vid_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] a, input logic [7:0] b, input int nv,
                             input bit corrupt, input bit mid_go, input bit exp_lock,
                             input string lock_req);
        logic [63:0] got, exp;
        logic [7:0]  exp_slot [8];
        int nbits = 0, last_c = 0, nstb = 0;
        bit sof_ok = 1, gap_ok = 1, stb_ok = 1;
        frame_no++;
        for (int k = 0; k < 4; k++) vb[k] = 8'((frame_no * 5 + k * 7 + 1) & 63);
        for (int k = 0; k < nv; k++) push(vb[k]);
        if (nv == 4) chk(vid_ready == 1'b0, "R5 ready low with buffer full", vid_ready, 0);
        exp_slot[0] = 8'hAA; exp_slot[1] = 8'h55; exp_slot[2] = a; exp_slot[3] = b;
        for (int k = 0; k < 4; k++) exp_slot[4+k] = (k < nv) ? vb[k] : 8'h00;
        exp = '0;
        for (int s = 0; s < 8; s++) exp = {exp[55:0], exp_slot[s]};
        got = '0;
        sine_a = a; sine_b = b; frame_go = 1'b1;
        @(negedge clk);
        frame_go = 1'b0;
        for (int c = 0; c < 530; c++) begin
            if (mid_go) frame_go = (c == 200);
            if (ser_en) begin
                got = {got[62:0], ser_bit};
                if (ser_sof != (nbits == 0)) sof_ok = 0;
                if (nbits > 0 && c - last_c != BD) gap_ok = 0;
                last_c = c;
                flip   = corrupt && (nbits == 0);
                nbits++;
            end else begin
                flip = 1'b0;
            end
            if (rx_strobe) begin
                nstb++;
                if (rx_slot < 3'd2 || rx_byte != exp_slot[rx_slot]) stb_ok = 0;
            end
            @(negedge clk);
        end
        frame_go = 1'b0;
        flip     = 1'b0;
        chk(nbits == 64, "R1 bits per frame", nbits, 64);
        chk(got == exp, "R1 and R6 frame contents", got, exp);
        chk(sof_ok, "R3 start marker only on bit 0", sof_ok, 1);
        chk(gap_ok, "R2 bit spacing", gap_ok, 1);
        chk(tx_underflow == (nv < 4), "R6 underflow flag", tx_underflow, (nv < 4));
        if (mid_go) chk(nbits == 64 && sof_ok, "R4 strobe during busy ignored", nbits, 64);
        if (exp_lock) chk(nstb == 6 && stb_ok, "R10 slot strobes while locked", nstb, 6);
        else          chk(nstb == 0, "R10 no strobes while unlocked", nstb, 0);
        chk(rx_locked == exp_lock, lock_req, rx_locked, exp_lock);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(ser_en == 0 && ser_sof == 0, "R11 serial idle after reset", ser_en, 0);
        chk(tx_underflow == 0, "R11 underflow clear after reset", tx_underflow, 0);
        chk(rx_locked == 0 && rx_strobe == 0, "R11 receiver idle after reset", rx_locked, 0);
        chk(vid_ready == 1, "R11 video ready after reset", vid_ready, 1);

        run_frame(8'h11, 8'h22, 4, 0, 0, 0, "R7 no lock after one sync");
        run_frame(8'h01, 8'h3F, 3, 0, 0, 0, "R7 no lock after two syncs");
        run_frame(8'h15, 8'h2A, 4, 0, 0, 1, "R7 lock on third sync");
        // fill-level sweep, every video count
        for (int nv = 0; nv <= 4; nv++)
            run_frame(8'(nv * 9 + 3), 8'(60 - nv * 11), nv, 0, 0, 1, "R7 lock held on good frames");
        run_frame(8'h07, 8'h38, 4, 0, 1, 1, "R4 lock held");
        run_frame(8'h12, 8'h21, 4, 1, 0, 1, "R8 single miss keeps lock");
        run_frame(8'h33, 8'h0C, 2, 0, 0, 1, "R8 lock after miss then hit");
        run_frame(8'h24, 8'h18, 4, 1, 0, 1, "R8 first of two misses");
        run_frame(8'h05, 8'h0A, 1, 1, 0, 0, "R8 two misses drop lock");
        run_frame(8'h2B, 8'h16, 4, 0, 0, 0, "R9 no relock after one sync");
        run_frame(8'h0F, 8'h30, 3, 0, 0, 0, "R9 no relock after two syncs");
        run_frame(8'h19, 8'h26, 4, 0, 0, 1, "R9 relock on third sync");
        run_frame(8'h3E, 8'h01, 0, 0, 0, 1, "R9 lock held after relock");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule